// File: doc/BRIEF.md
# Threshold-Driven Audio Sample FIFO

This block sits between a system-side DMA engine and a serial audio port and holds two independent sample queues, one per direction. On the transmit path the DMA engine pushes 32-bit words through a valid/ready channel and the serial port pops one word per slot. On the receive path the serial port pushes one word per slot and the DMA engine pulls words back through a request/ready channel with a registered data return.

Each direction has a small configuration register made of a transfer mode (element or block) and a threshold. The threshold holds the wanted sample count minus one. A request line tells the DMA engine when to act. On transmit, once the line goes high it stays high until the queue is completely full. It is raised again only when the free space can take a full block. On receive, the line is high whenever a full block is waiting. The configuration of a direction can only change while that direction is disabled. Disabling a direction also empties its queue.

Top module: `thresh_audio_fifo`

## Requirements
- R1: After a synchronous reset, both levels read 0, both request lines and both sticky error flags are low, `ser_tdata` reads 0, and both configuration registers hold element mode (`cfg_blk`=0) with threshold 0.
- R2: Each queue holds exactly DEPTH (default 1024) words and returns them in the order they entered. `tx_level` and `rx_level` give the stored word count. `dma_wready` is high exactly when transmit is enabled and its queue is not full. `dma_rready` is high exactly when receive is enabled and its queue is not empty.
- R3: The transmit request rises when the free space after an edge is at least effective threshold + 1. Once high, it stays high until the level reaches DEPTH. Right after enable it is therefore high until the whole depth has been written.
- R4: The receive request is high exactly when the receive level is at least effective threshold + 1.
- R5: In element mode (`cfg_blk`=0) the effective threshold is 0, whatever threshold value is stored.
- R6: In block mode (`cfg_blk`=1) the effective threshold is the stored value, so that one request moves the stored value + 1 samples.
- R7: A write with `cfg_wr`=1 loads `cfg_blk` and `cfg_thr` into the transmit register when `cfg_dir`=0, or into the receive register when `cfg_dir`=1. The load happens only if that direction's enable is low at the edge. Otherwise the write is ignored.
- R8: While a direction's enable is low, its level is 0 and its request is low. Its stored words are discarded, and DMA and serial accesses on that direction have no effect.
- R9: A serial pop on an empty transmit queue sets `tx_underrun` and loads 0 into `ser_tdata`. A serial push into a full receive queue is dropped and sets `rx_overrun`. The fullness and emptiness tests use the state before the edge.
- R10: `xrun_clr` bit 0 clears `tx_underrun` and bit 1 clears `rx_overrun`. When a new error and a clear land on the same edge, the new error wins.
- R11: `tx_max_thr` and `rx_max_thr` both read DEPTH-1.
- R12: The word taken by a serial pop appears on `ser_tdata` one cycle after the pop edge. A receive word accepted when both `dma_rreq` and `dma_rready` are high appears on `dma_rdata`, with a one-cycle `dma_rdata_valid` pulse, one cycle after the accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_dir | input | 1 | Target of the write: 0 transmit, 1 receive |
| cfg_blk | input | 1 | Transfer mode: 0 element, 1 block |
| cfg_thr | input | AW (10) | Threshold, sample count minus one |
| tx_en | input | 1 | Transmit direction enable; low flushes it |
| rx_en | input | 1 | Receive direction enable; low flushes it |
| xrun_clr | input | 2 | Write-one-to-clear: bit 0 underrun, bit 1 overrun |
| dma_wvalid | input | 1 | DMA transmit word valid |
| dma_wdata | input | DATA_W (32) | DMA transmit word |
| dma_wready | output | 1 | Transmit queue can accept a word |
| ser_pop | input | 1 | Serial port takes one transmit word |
| ser_tdata | output | DATA_W (32) | Transmit word returned after a pop |
| tx_req | output | 1 | Transmit DMA request |
| tx_level | output | AW+1 (11) | Transmit stored word count |
| tx_underrun | output | 1 | Sticky pop-on-empty flag |
| tx_max_thr | output | AW (10) | Largest transmit threshold |
| ser_push | input | 1 | Serial port delivers one receive word |
| ser_rxdata | input | DATA_W (32) | Receive word from the serial port |
| dma_rreq | input | 1 | DMA asks for a receive word |
| dma_rready | output | 1 | Receive queue has a word to give |
| dma_rdata | output | DATA_W (32) | Receive word returned to DMA |
| dma_rdata_valid | output | 1 | `dma_rdata` carries a new word this cycle |
| rx_req | output | 1 | Receive DMA request |
| rx_level | output | AW+1 (11) | Receive stored word count |
| rx_overrun | output | 1 | Sticky push-on-full flag |
| rx_max_thr | output | AW (10) | Largest receive threshold |

## Verification
The bench fills the transmit queue to its full depth straight after enable. A design that ends the transmit request as soon as the threshold is met would drop it early there. With a 256-sample block it then drains past the point where the free space equals the block size. An off-by-one in the count-minus-one threshold would re-raise the request one sample early or late. The threshold is also set to DEPTH-1 on both sides, where the request may only appear for a completely empty transmit queue or a completely full receive queue. The bench writes configuration while a direction is enabled, toggles enable under traffic, and lands clears on the same edge as new errors, which exposes designs that let the threshold drift, keep stale words after a flush, or let a clear hide an error.

// File: rtl/taf_pkg.sv
package taf_pkg;

  typedef enum logic {
    XFER_ELEM  = 1'b0,
    XFER_BLOCK = 1'b1
  } xfer_mode_e;

endpackage

// File: rtl/taf_store.sv
module taf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     cnt,
  output logic [CW-1:0]     cnt_nxt,
  output logic              xrun_evt
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              full, empty, wr_ok, rd_ok, rd_miss;

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign wr_ok   = en && wr && !full;
  assign rd_ok   = en && rd && !empty;
  assign rd_miss = en && rd && empty;
  assign xrun_evt = rd_miss || (en && wr && full);

  always_comb begin
    if (!en) cnt_nxt = '0;
    else     cnt_nxt = cnt + CW'(wr_ok) - CW'(rd_ok);
  end

  // storage array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (rd_ok)   rdata <= mem[rptr];
    else if (rd_miss) rdata <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      cnt <= cnt_nxt;
    end
  end

  p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);

  p_drop_keeps_full_r9: assert property (@(posedge clk) disable iff (rst)
    (en && wr && full && !rd) |=> (cnt == FULL_CNT));

  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));

endmodule

// File: rtl/taf_ctrl.sv
module taf_ctrl
  import taf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter bit IS_TX = 1'b1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cfg_we,
  input  logic          cfg_blk,
  input  logic [AW-1:0] cfg_thr,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          xrun_evt,
  input  logic          xrun_clr,
  output logic          req,
  output logic          xrun,
  output logic [AW-1:0] max_thr
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  xfer_mode_e    mode_q;
  logic [AW-1:0] thr_q;
  logic [AW-1:0] eff_thr;
  logic [CW-1:0] need;
  logic          req_nxt;

  assign max_thr = AW'(DEPTH - 1);
  assign eff_thr = (mode_q == XFER_BLOCK) ? thr_q : '0;
  assign need    = {1'b0, eff_thr} + 1'b1;

  // configuration only loads while the direction is idle
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= XFER_ELEM;
      thr_q  <= '0;
    end else if (cfg_we && !en) begin
      mode_q <= xfer_mode_e'(cfg_blk);
      thr_q  <= cfg_thr;
    end
  end

  generate
    if (IS_TX) begin : g_tx_req
      logic [CW-1:0] free_nxt;
      assign free_nxt = FULL_CNT - cnt_nxt;
      // raise on room for a block, hold until completely full
      assign req_nxt = en && (req ? (cnt_nxt != FULL_CNT) : (free_nxt >= need));

      p_tx_req_until_full_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> ((cnt == FULL_CNT) || !$past(en)));
    end else begin : g_rx_req
      assign req_nxt = en && (cnt_nxt >= need);

      p_rx_req_level_r4: assert property (@(posedge clk) disable iff (rst)
        req |-> (cnt > {1'b0, eff_thr}));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      xrun <= 1'b0;
    end else begin
      req  <= req_nxt;
      xrun <= (xrun && !xrun_clr) || xrun_evt;
    end
  end

  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (rst)
    en |=> ($stable(thr_q) && $stable(mode_q)));

  p_xrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(xrun) |-> $past(xrun_clr));

endmodule

// File: rtl/thresh_audio_fifo.sv
module thresh_audio_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_dir,
  input  logic              cfg_blk,
  input  logic [AW-1:0]     cfg_thr,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [1:0]        xrun_clr,
  input  logic              dma_wvalid,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_wready,
  input  logic              ser_pop,
  output logic [DATA_W-1:0] ser_tdata,
  output logic              tx_req,
  output logic [CW-1:0]     tx_level,
  output logic              tx_underrun,
  output logic [AW-1:0]     tx_max_thr,
  input  logic              ser_push,
  input  logic [DATA_W-1:0] ser_rxdata,
  input  logic              dma_rreq,
  output logic              dma_rready,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dma_rdata_valid,
  output logic              rx_req,
  output logic [CW-1:0]     rx_level,
  output logic              rx_overrun,
  output logic [AW-1:0]     rx_max_thr
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] tx_cnt_nxt, rx_cnt_nxt;
  logic          tx_evt, rx_evt;
  logic          tx_wr, rx_rd;

  assign dma_wready = tx_en && (tx_level != FULL_CNT);
  assign dma_rready = rx_en && (rx_level != '0);
  assign tx_wr      = dma_wvalid && dma_wready;
  assign rx_rd      = dma_rreq && dma_rready;

  taf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_store_i (
    .clk(clk), .rst(rst), .en(tx_en),
    .wr(tx_wr), .wdata(dma_wdata),
    .rd(ser_pop), .rdata(ser_tdata),
    .cnt(tx_level), .cnt_nxt(tx_cnt_nxt), .xrun_evt(tx_evt)
  );

  taf_ctrl #(.DEPTH(DEPTH), .IS_TX(1'b1)) tx_ctrl_i (
    .clk(clk), .rst(rst), .en(tx_en),
    .cfg_we(cfg_wr && !cfg_dir), .cfg_blk(cfg_blk), .cfg_thr(cfg_thr),
    .cnt(tx_level), .cnt_nxt(tx_cnt_nxt),
    .xrun_evt(tx_evt), .xrun_clr(xrun_clr[0]),
    .req(tx_req), .xrun(tx_underrun), .max_thr(tx_max_thr)
  );

  taf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_store_i (
    .clk(clk), .rst(rst), .en(rx_en),
    .wr(ser_push), .wdata(ser_rxdata),
    .rd(rx_rd), .rdata(dma_rdata),
    .cnt(rx_level), .cnt_nxt(rx_cnt_nxt), .xrun_evt(rx_evt)
  );

  taf_ctrl #(.DEPTH(DEPTH), .IS_TX(1'b0)) rx_ctrl_i (
    .clk(clk), .rst(rst), .en(rx_en),
    .cfg_we(cfg_wr && cfg_dir), .cfg_blk(cfg_blk), .cfg_thr(cfg_thr),
    .cnt(rx_level), .cnt_nxt(rx_cnt_nxt),
    .xrun_evt(rx_evt), .xrun_clr(xrun_clr[1]),
    .req(rx_req), .xrun(rx_overrun), .max_thr(rx_max_thr)
  );

  always_ff @(posedge clk) begin
    if (rst) dma_rdata_valid <= 1'b0;
    else     dma_rdata_valid <= rx_rd;
  end

  p_rvalid_follows_accept_r12: assert property (@(posedge clk) disable iff (rst)
    dma_rdata_valid |-> $past(dma_rreq && dma_rready));

endmodule

// File: tb/thresh_audio_fifo_tb_top.sv
`timescale 1ns/1ps
module thresh_audio_fifo_tb_top;

  localparam int DW = 32;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_dir = 0, cfg_blk = 0;
  logic [AW-1:0] cfg_thr = '0;
  logic tx_en = 0, rx_en = 0;
  logic [1:0] xrun_clr = '0;
  logic dma_wvalid = 0;
  logic [DW-1:0] dma_wdata = '0;
  logic ser_pop = 0, ser_push = 0, dma_rreq = 0;
  logic [DW-1:0] ser_rxdata = '0;
  logic dma_wready, tx_req, tx_underrun, dma_rready, dma_rdata_valid, rx_req, rx_overrun;
  logic [DW-1:0] ser_tdata, dma_rdata;
  logic [CW-1:0] tx_level, rx_level;
  logic [AW-1:0] tx_max_thr, rx_max_thr;

  always #4 clk = ~clk;

  thresh_audio_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dir(cfg_dir), .cfg_blk(cfg_blk),
    .cfg_thr(cfg_thr), .tx_en(tx_en), .rx_en(rx_en), .xrun_clr(xrun_clr),
    .dma_wvalid(dma_wvalid), .dma_wdata(dma_wdata), .dma_wready(dma_wready),
    .ser_pop(ser_pop), .ser_tdata(ser_tdata), .tx_req(tx_req), .tx_level(tx_level),
    .tx_underrun(tx_underrun), .tx_max_thr(tx_max_thr),
    .ser_push(ser_push), .ser_rxdata(ser_rxdata), .dma_rreq(dma_rreq),
    .dma_rready(dma_rready), .dma_rdata(dma_rdata), .dma_rdata_valid(dma_rdata_valid),
    .rx_req(rx_req), .rx_level(rx_level), .rx_overrun(rx_overrun), .rx_max_thr(rx_max_thr)
  );

  // behavioural reference model
  int unsigned tq[$];
  int unsigned rq[$];
  bit m_tx_req = 0, m_rx_req = 0, m_unf = 0, m_ovf = 0, m_rvalid = 0;
  logic [DW-1:0] m_tdata = '0, m_rdata = '0;
  int m_tthr = 0, m_rthr = 0;
  bit m_tblk = 0, m_rblk = 0;
  int tsz, rsz, teff, reff;
  bit t_miss, r_drop;

  always @(posedge clk) begin
    if (rst) begin
      tq.delete(); rq.delete();
      m_tx_req = 0; m_rx_req = 0; m_unf = 0; m_ovf = 0; m_rvalid = 0;
      m_tdata = '0; m_rdata = '0;
      m_tthr = 0; m_rthr = 0; m_tblk = 0; m_rblk = 0;
    end else begin
      tsz = tq.size(); rsz = rq.size();
      t_miss = 0; r_drop = 0;
      if (!tx_en) tq.delete();
      else begin
        if (ser_pop) begin
          if (tsz == 0) begin t_miss = 1; m_tdata = '0; end
          else m_tdata = tq.pop_front();
        end
        if (dma_wvalid && tsz < DEPTH) tq.push_back(dma_wdata);
      end
      m_unf = (m_unf && !xrun_clr[0]) || t_miss;
      teff = m_tblk ? m_tthr : 0;
      if (!tx_en) m_tx_req = 0;
      else if (m_tx_req) m_tx_req = (tq.size() != DEPTH);
      else m_tx_req = ((DEPTH - tq.size()) >= teff + 1);

      m_rvalid = 0;
      if (!rx_en) rq.delete();
      else begin
        if (dma_rreq && rsz > 0) begin m_rdata = rq.pop_front(); m_rvalid = 1; end
        if (ser_push) begin
          if (rsz == DEPTH) r_drop = 1;
          else rq.push_back(ser_rxdata);
        end
      end
      m_ovf = (m_ovf && !xrun_clr[1]) || r_drop;
      reff = m_rblk ? m_rthr : 0;
      m_rx_req = rx_en && (rq.size() >= reff + 1);

      if (cfg_wr && !cfg_dir && !tx_en) begin m_tblk = cfg_blk; m_tthr = cfg_thr; end
      if (cfg_wr &&  cfg_dir && !rx_en) begin m_rblk = cfg_blk; m_rthr = cfg_thr; end
    end
  end

  int nvec = 0, nerr = 0;
  string phase = "R1 reset";
  bit done = 0;

  task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s (%s) actual=%0h expected=%0h at %0t", tag, nm, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R2",  "tx_level",     tx_level, tq.size());
      chk("R3",  "tx_req",       tx_req, m_tx_req);
      chk("R9",  "tx_underrun",  tx_underrun, m_unf);
      chk("R12", "ser_tdata",    ser_tdata, m_tdata);
      chk("R2",  "dma_wready",   dma_wready, (tx_en === 1'b1) && tq.size() < DEPTH);
      chk("R2",  "dma_rready",   dma_rready, (rx_en === 1'b1) && rq.size() > 0);
      chk("R2",  "rx_level",     rx_level, rq.size());
      chk("R4",  "rx_req",       rx_req, m_rx_req);
      chk("R9",  "rx_overrun",   rx_overrun, m_ovf);
      chk("R12", "dma_rdata_valid", dma_rdata_valid, m_rvalid);
      if (m_rvalid) chk("R12", "dma_rdata", dma_rdata, m_rdata);
      chk("R11", "tx_max_thr",   tx_max_thr, DEPTH - 1);
      chk("R11", "rx_max_thr",   rx_max_thr, DEPTH - 1);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg(bit dir, bit blk, int thr);
    cfg_wr = 1; cfg_dir = dir; cfg_blk = blk; cfg_thr = AW'(thr);
    step();
    cfg_wr = 0;
  endtask

  task automatic tx_traffic(int n, int pw, int pp);
    for (int i = 0; i < n; i++) begin
      dma_wvalid = ($urandom % 100) < pw;
      dma_wdata  = $urandom;
      ser_pop    = ($urandom % 100) < pp;
      step();
    end
    dma_wvalid = 0; ser_pop = 0;
  endtask

  task automatic rx_traffic(int n, int pp, int pr);
    for (int i = 0; i < n; i++) begin
      ser_push   = ($urandom % 100) < pp;
      ser_rxdata = $urandom;
      dma_rreq   = ($urandom % 100) < pr;
      step();
    end
    ser_push = 0; dma_rreq = 0;
  endtask

  initial begin
    step(); idle(2);
    rst = 0;
    phase = "R1 reset"; idle(2);

    phase = "R5 element TX full first fill";
    tx_en = 1;
    tx_traffic(1100, 100, 0);
    tx_traffic(20, 0, 100);
    tx_traffic(1500, 60, 55);

    phase = "R7 TX cfg ignored while enabled";
    cfg(0, 1, 500);
    tx_traffic(300, 50, 50);

    phase = "R8 TX flush";
    tx_en = 0;
    tx_traffic(20, 100, 100);

    phase = "R9 TX underrun";
    tx_en = 1;
    tx_traffic(5, 0, 100);
    idle(3);

    phase = "R10 clear with simultaneous event";
    xrun_clr = 2'b01; ser_pop = 1; step();
    ser_pop = 0; step();
    xrun_clr = 2'b00; idle(2);

    phase = "R6 TX block threshold 255";
    tx_en = 0; step();
    cfg(0, 1, 255);
    tx_en = 1;
    tx_traffic(1100, 100, 0);
    tx_traffic(300, 0, 100);
    tx_traffic(2000, 50, 50);

    phase = "R6 TX block threshold max";
    tx_en = 0; step();
    cfg(0, 1, DEPTH - 1);
    tx_en = 1;
    tx_traffic(1100, 100, 0);
    tx_traffic(1100, 0, 100);
    xrun_clr = 2'b01; step(); xrun_clr = 2'b00;

    phase = "R4 RX element";
    rx_en = 1;
    rx_traffic(50, 50, 30);
    rx_traffic(1500, 70, 40);

    phase = "R7 RX cfg ignored while enabled";
    cfg(1, 1, 7);
    rx_traffic(200, 50, 50);

    phase = "R6 RX block threshold 7";
    rx_en = 0; step();
    cfg(1, 1, 7);
    rx_en = 1;
    rx_traffic(30, 100, 0);
    rx_traffic(1100, 60, 40);

    phase = "R9 RX overrun";
    rx_traffic(1100, 100, 0);
    phase = "R10 RX clear";
    xrun_clr = 2'b10; step(); xrun_clr = 2'b00; idle(2);

    phase = "R6 RX block threshold max";
    rx_en = 0; step();
    cfg(1, 1, DEPTH - 1);
    rx_en = 1;
    rx_traffic(1030, 100, 0);
    rx_traffic(50, 0, 100);

    phase = "R8 RX flush";
    rx_en = 0;
    rx_traffic(20, 100, 100);
    rx_en = 1; idle(3);

    phase = "R2 both directions together";
    for (int i = 0; i < 1500; i++) begin
      dma_wvalid = ($urandom % 100) < 55;
      dma_wdata  = $urandom;
      ser_pop    = ($urandom % 100) < 50;
      ser_push   = ($urandom % 100) < 50;
      ser_rxdata = $urandom;
      dma_rreq   = ($urandom % 100) < 55;
      xrun_clr   = (($urandom % 100) < 3) ? 2'b11 : 2'b00;
      if (i == 700) tx_en = 0;
      if (i == 710) tx_en = 1;
      step();
    end
    dma_wvalid = 0; ser_pop = 0; ser_push = 0; dma_rreq = 0; xrun_clr = 0;
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog (%s) actual=hung expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule